// File: doc/BRIEF.md
# Three-Phase Chained Firing Delay Sequencer

This block produces gate pulse trains for three thyristor phases (A, B, C) from a single master trigger. A rising trigger edge arms a master delay down-counter. When that counter runs out, the first inter-phase counter is armed. When the first inter-phase counter runs out, the second one is armed. Each stage has an active-low enable that is low while the stage is counting. All counting advances on a one-cycle tick strobe, which is nominally one strobe every 5 µs.

Each stage holds a stored delay value, written through a small write port. A counter takes in a new value only while it is idle, so a write made during a run does not disturb that run. Each phase output opens a window when its own stage finishes. The window closes when the following stage finishes, and for phase C it closes at the next accepted trigger. Inside the window, the output carries a tick-derived carrier whose first pulse is widened. A global enable gates all three outputs.

Top module: `phase_fire_seq`

## Requirements
- R1: After reset all stage enables are high, all gate and done outputs are low, the stored master delay is 1 tick and both stored inter-phase delays are 60 ticks.
- R2: A rising trigger edge seen while no stage is counting drives the master enable (bit 0) low at the next clock edge. It stays low for exactly N tick strobes, where N is the stored master delay. Ticks begin counting one cycle after the enable falls.
- R3: On the clock edge where a stage's enable returns high, the next stage's enable goes low in the order master, inter-phase 1 (bit 1), inter-phase 2 (bit 2). At most one enable is low at any time.
- R4: A stored delay of 0 behaves as a delay of 1 tick.
- R5: done_o bit k is high for exactly one cycle, on the same clock edge where enable bit k returns high.
- R6: wr_sel 0, 1 and 2 select the master, inter-phase 1 and inter-phase 2 values, and wr_sel 3 writes nothing. A write to a stage that is counting does not change its current run and takes effect on its next run.
- R7: A rising trigger edge that arrives while any stage is counting is ignored. The run in progress keeps its timing and is not restarted.
- R8: Gate A (bit 0) can be high only while inter-phase 1 is counting, and gate B (bit 1) only while inter-phase 2 is counting. Gate C (bit 2) can be high only from the end of inter-phase 2 until the next accepted trigger.
- R9: Each window opens with a pulse of 3·H ticks, where H is the carrier half-period in ticks. After that the output alternates H ticks low and H ticks high, and it is high in the first cycle after the window opens.
- R10: While glob_en_i is low all gate outputs are low in the same cycle, without affecting the delay timing.
- R11: Counters and the carrier advance only on cycles where tick_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle count strobe |
| trig_i | input | 1 | Master trigger level, already synchronous |
| glob_en_i | input | 1 | Global firing enable |
| wr_en_i | input | 1 | Delay write strobe |
| wr_sel_i | input | 2 | Stage selected for the write |
| wr_data_i | input | CNT_W | Delay value in ticks |
| stage_en_n_o | output | 3 | Active-low enables, one per counting stage |
| done_o | output | 3 | One-cycle stage-finished pulses |
| gate_o | output | 3 | Gate pulse trains for phases A, B, C |

## Verification
Directed chains with the tick held high measure each enable's low time against the stored delays. These cover the reset defaults, a zero value, and a write made mid-run, which separates counting errors from reload-timing errors. A second trigger inside a running chain shows whether the chain restarts. The widened-first-pulse pattern is read from gate C and compared with the expected shape. Long random runs with gapped ticks, toggling triggers, global-enable drops and writes to all four select codes are compared every cycle with a bench model. These runs expose ordering, window and tick-gating faults that the steady directed runs cannot reach.

// File: rtl/phase_fire_pkg.sv
package phase_fire_pkg;
   localparam int NSTG = 3;

   typedef enum logic [1:0] {
      SEL_MASTER = 2'd0,
      SEL_PH1    = 2'd1,
      SEL_PH2    = 2'd2,
      SEL_NONE   = 2'd3
   } stage_sel_e;

   // value of zero behaves as one tick
   function automatic logic [31:0] floor_one(input logic [31:0] v);
      return (v == 32'd0) ? 32'd1 : v;
   endfunction
endpackage

// File: rtl/fire_stage.sv
module fire_stage #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             start_i,
   input  logic [CNT_W-1:0] load_i,
   output logic             busy_o,
   output logic             fin_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!busy_q) begin
         cnt_q <= load_i;
         if (start_i) busy_q <= 1'b1;
      end else if (tick_i) begin
         if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
         else                    cnt_q  <= cnt_q - CNT_W'(1);
      end
   end

   assign busy_o = busy_q;
   assign fin_o  = busy_q & tick_i & (cnt_q == CNT_W'(1));
endmodule

// File: rtl/fire_shaper.sv
module fire_shaper #(
   parameter int HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic open_i,
   input  logic win_i,
   input  logic en_i,
   output logic gate_o
);
   localparam int PER   = 2 * HALF;
   localparam int SUB_W = $clog2(PER + 1);

   logic [SUB_W-1:0] sub_q;
   logic             later_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q   <= '0;
         later_q <= 1'b0;
      end else if (open_i) begin
         sub_q   <= '0;
         later_q <= 1'b0;
      end else if (win_i && tick_i) begin
         if (sub_q == SUB_W'(PER - 1)) begin
            sub_q   <= '0;
            later_q <= 1'b1;
         end else begin
            sub_q <= sub_q + SUB_W'(1);
         end
      end
   end

   assign gate_o = en_i & win_i & (!later_q | (sub_q < SUB_W'(HALF)));
endmodule

// File: rtl/phase_fire_seq.sv
module phase_fire_seq #(
   parameter int CNT_W      = 12,
   parameter int RST_MASTER = 1,
   parameter int RST_PHASE  = 60,
   parameter int CAR_HALF   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             trig_i,
   input  logic             glob_en_i,
   input  logic             wr_en_i,
   input  logic [1:0]       wr_sel_i,
   input  logic [CNT_W-1:0] wr_data_i,
   output logic [2:0]       stage_en_n_o,
   output logic [2:0]       done_o,
   output logic [2:0]       gate_o
);
   import phase_fire_pkg::*;

   if (CNT_W < 2)                   begin : g_bad_w   $error("CNT_W too small");       end
   if (CAR_HALF < 1)                begin : g_bad_h   $error("CAR_HALF must be >= 1"); end
   if (RST_PHASE >= (1 << CNT_W))   begin : g_bad_rp  $error("RST_PHASE too wide");    end
   if (RST_MASTER >= (1 << CNT_W))  begin : g_bad_rm  $error("RST_MASTER too wide");   end

   logic              trig_q;
   logic              accept;
   logic [NSTG-1:0]   busy, fin, start, win;
   logic              tail_win_q;
   logic [CNT_W-1:0]  stored_q [NSTG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_q <= 1'b0;
      else        trig_q <= trig_i;
   end

   assign accept = trig_i & ~trig_q & ~(|busy);

   for (genvar k = 0; k < NSTG; k++) begin : g_stage
      localparam int RV = (k == 0) ? RST_MASTER : RST_PHASE;
      logic [CNT_W-1:0] ld;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stored_q[k] <= CNT_W'(RV);
         else if (wr_en_i && (wr_sel_i == 2'(k)))
            stored_q[k] <= wr_data_i;
      end

      assign ld = CNT_W'(floor_one(32'(stored_q[k])));

      if (k == 0) begin : g_first
         assign start[k] = accept;
      end else begin : g_next
         assign start[k] = fin[k-1];
      end

      fire_stage #(.CNT_W(CNT_W)) stage_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick_i  (tick_i),
         .start_i (start[k]),
         .load_i  (ld),
         .busy_o  (busy[k]),
         .fin_o   (fin[k])
      );

      if (k < NSTG - 1) begin : g_win_mid
         assign win[k] = busy[k+1];
      end else begin : g_win_tail
         assign win[k] = tail_win_q;
      end

      fire_shaper #(.HALF(CAR_HALF)) shaper_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick_i (tick_i),
         .open_i (fin[k]),
         .win_i  (win[k]),
         .en_i   (glob_en_i),
         .gate_o (gate_o[k])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tail_win_q <= 1'b0;
         done_o     <= '0;
      end else begin
         done_o <= fin;
         if (accept)                 tail_win_q <= 1'b0;
         else if (fin[NSTG-1])       tail_win_q <= 1'b1;
      end
   end

   assign stage_en_n_o = ~busy;
endmodule

// File: rtl/phase_fire_chk.sv
module phase_fire_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       trig_i,
   input logic       trig_q,
   input logic       glob_en_i,
   input logic [2:0] stage_en_n_o,
   input logic [2:0] done_o,
   input logic [2:0] gate_o
);
   // R2
   master_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stage_en_n_o[0]) |-> $past(trig_i && !trig_q));

   // R3
   chain_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stage_en_n_o[1]) |-> $rose(stage_en_n_o[0]));

   // R3
   chain_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stage_en_n_o[2]) |-> $rose(stage_en_n_o[1]));

   // R3
   one_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~stage_en_n_o) <= 1);

   // R5
   done_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stage_en_n_o[0]) |-> done_o[0]);

   // R5
   done_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o[2] |-> $rose(stage_en_n_o[2]));

   // R7
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stage_en_n_o[1] |=> !($fell(stage_en_n_o[0])));

   // R8
   win_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gate_o[0] |-> !stage_en_n_o[1]);

   // R8
   win_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gate_o[1] |-> !stage_en_n_o[2]);

   // R10
   glob_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_en_i |-> (gate_o == 3'b000));
endmodule

bind phase_fire_seq phase_fire_chk chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .trig_i       (trig_i),
   .trig_q       (trig_q),
   .glob_en_i    (glob_en_i),
   .stage_en_n_o (stage_en_n_o),
   .done_o       (done_o),
   .gate_o       (gate_o)
);

// File: tb/phase_fire_seq_tb.sv
module phase_fire_seq_tb_top;
   localparam int CNT_W = 12;
   localparam int HALF  = 4;
   localparam int PER   = 2 * HALF;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tick_i = 1'b0, trig_i = 1'b0, glob_en_i = 1'b1;
   logic             wr_en_i = 1'b0;
   logic [1:0]       wr_sel_i = 2'd0;
   logic [CNT_W-1:0] wr_data_i = '0;
   logic [2:0]       stage_en_n_o, done_o, gate_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   phase_fire_seq #(.CNT_W(CNT_W), .RST_MASTER(1), .RST_PHASE(60), .CAR_HALF(HALF)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .trig_i(trig_i), .glob_en_i(glob_en_i),
      .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
      .stage_en_n_o(stage_en_n_o), .done_o(done_o), .gate_o(gate_o));

   // reference model built from the requirements
   logic             m_tq, m_tail;
   logic [2:0]       m_busy, m_done;
   logic [CNT_W-1:0] m_cnt [3];
   logic [CNT_W-1:0] m_val [3];
   int               m_sub [3];
   logic [2:0]       m_later;

   function automatic int eff(input logic [CNT_W-1:0] v);
      return (v == 0) ? 1 : int'(v);
   endfunction

   function automatic bit shape_at(input int i);
      return (i < PER) || ((i % PER) < HALF);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_tq <= 1'b0; m_tail <= 1'b0; m_busy <= '0; m_done <= '0; m_later <= '0;
         for (int k = 0; k < 3; k++) begin
            m_cnt[k] <= '0; m_sub[k] <= 0;
            m_val[k] <= (k == 0) ? CNT_W'(1) : CNT_W'(60);
         end
      end else begin
         logic       acc;
         logic [2:0] f, st, w;
         acc = trig_i && !m_tq && (m_busy == 3'b000);
         for (int k = 0; k < 3; k++) f[k] = m_busy[k] && tick_i && (m_cnt[k] == 1);
         st = {f[1], f[0], acc};
         w  = {m_tail, m_busy[2], m_busy[1]};
         for (int k = 0; k < 3; k++) begin
            if (!m_busy[k]) begin
               m_cnt[k] <= CNT_W'(eff(m_val[k]));
               if (st[k]) m_busy[k] <= 1'b1;
            end else if (tick_i) begin
               if (m_cnt[k] == 1) m_busy[k] <= 1'b0;
               else               m_cnt[k]  <= m_cnt[k] - 1;
            end
            if (f[k]) begin
               m_sub[k] <= 0; m_later[k] <= 1'b0;
            end else if (w[k] && tick_i) begin
               if (m_sub[k] == PER - 1) begin m_sub[k] <= 0; m_later[k] <= 1'b1; end
               else m_sub[k] <= m_sub[k] + 1;
            end
            if (wr_en_i && wr_sel_i == 2'(k)) m_val[k] <= wr_data_i;
         end
         m_done <= f;
         m_tq   <= trig_i;
         if (acc) m_tail <= 1'b0;
         else if (f[2]) m_tail <= 1'b1;
      end
   end

   function automatic logic [2:0] exp_gate();
      logic [2:0] w, g;
      w = {m_tail, m_busy[2], m_busy[1]};
      for (int k = 0; k < 3; k++)
         g[k] = glob_en_i && w[k] && (!m_later[k] || (m_sub[k] < HALF));
      return g;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(stage_en_n_o == ~m_busy, "R2,R3,R11 enables", stage_en_n_o, ~m_busy);
         check(done_o == m_done, "R5 done", done_o, m_done);
         check(gate_o == exp_gate(), "R8,R9,R10 gates", gate_o, exp_gate());
      end
   end

   task automatic cyc();
      @(posedge clk); #2;
   endtask

   task automatic wr(input logic [1:0] s, input logic [CNT_W-1:0] d);
      wr_en_i = 1'b1; wr_sel_i = s; wr_data_i = d;
      cyc();
      wr_en_i = 1'b0;
   endtask

   // runs one chain with tick held high, measuring enable low times and gate C shape
   task automatic run_chain(output int lo0, output int lo1, output int lo2, input int retrig_at,
                            input int mid_wr);
      int n = 0; int ci = -1; bit seen2 = 0;
      lo0 = 0; lo1 = 0; lo2 = 0;
      tick_i = 1'b1;
      trig_i = 1'b1; cyc(); trig_i = 1'b0;
      while (n < 3000) begin
         if (n == retrig_at) trig_i = 1'b1;
         if (n == retrig_at + 1) trig_i = 1'b0;
         if (n == mid_wr) begin wr_en_i = 1'b1; wr_sel_i = 2'd0; wr_data_i = CNT_W'(5); end
         if (n == mid_wr + 1) wr_en_i = 1'b0;
         @(negedge clk);
         if (!stage_en_n_o[0]) lo0++;
         if (!stage_en_n_o[1]) lo1++;
         if (!stage_en_n_o[2]) begin lo2++; seen2 = 1; end
         if (seen2 && stage_en_n_o[2] && ci < 0) ci = 0;
         if (ci >= 0) begin
            check(gate_o[2] == shape_at(ci), "R9 shape", gate_o[2], shape_at(ci));
            ci++;
            if (ci == 3 * PER) break;
         end
         @(posedge clk); #2;
         n++;
      end
      trig_i = 1'b0;
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual 1 expected 0");
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int a, b, c;
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check(stage_en_n_o == 3'b111, "R1 enables", stage_en_n_o, 7);
      check(gate_o == 3'b000, "R1 gates", gate_o, 0);
      check(done_o == 3'b000, "R1 done", done_o, 0);
      #4; rst_n = 1'b1;
      cyc(); cyc();

      // R1 default delays
      run_chain(a, b, c, -10, -10);
      check(a == 1,  "R1 master default", a, 1);
      check(b == 60, "R1 ph1 default", b, 60);
      check(c == 60, "R1 ph2 default", c, 60);

      // R2 programmed values
      wr(2'd0, 12'd17); wr(2'd1, 12'd9); wr(2'd2, 12'd23);
      run_chain(a, b, c, -10, -10);
      check(a == 17, "R2 master length", a, 17);
      check(b == 9,  "R3 ph1 length", b, 9);
      check(c == 23, "R3 ph2 length", c, 23);

      // R4 zero value; R6 select 3 writes nothing
      wr(2'd1, 12'd0); wr(2'd3, 12'd2);
      run_chain(a, b, c, -10, -10);
      check(b == 1,  "R4 zero as one", b, 1);
      check(a == 17, "R6 sel3 master kept", a, 17);
      check(c == 23, "R6 sel3 ph2 kept", c, 23);

      // R7 retrigger mid run; R6 write during run
      wr(2'd0, 12'd40);
      run_chain(a, b, c, 10, 20);
      check(a == 40, "R7 retrigger ignored", a, 40);
      check(a == 40, "R6 current run kept", a, 40);
      run_chain(a, b, c, -10, -10);
      check(a == 5, "R6 next run uses new value", a, 5);

      // R10 global disable inside gate C window
      glob_en_i = 1'b0;
      @(negedge clk);
      check(gate_o == 3'b000, "R10 disabled", gate_o, 0);
      check(stage_en_n_o == 3'b111, "R10 timing unaffected", stage_en_n_o, 7);
      @(posedge clk); #2; glob_en_i = 1'b1;

      // random phase
      for (int i = 0; i < 30000; i++) begin
         tick_i    = ($urandom % 4) != 0;
         if (($urandom % 25) == 0) trig_i = ~trig_i;
         glob_en_i = ($urandom % 16) != 0;
         wr_en_i   = ($urandom % 20) == 0;
         wr_sel_i  = 2'($urandom % 4);
         wr_data_i = (($urandom % 5) == 0) ? '0 : CNT_W'($urandom % 24);
         cyc();
      end
      wr_en_i = 1'b0;
      cyc();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule